// File: doc/BRIEF.md
# FM/MFM Byte Cell Encoder

This block sits in the write path of a disk recording channel. It turns each accepted data byte into a 16-cell recording frame and shifts that frame out one cell per clock, most significant cell first. Every frame alternates clock cells and data cells, and the clock cell comes first. A density select chooses between FM, where every clock cell is present, and MFM, where a clock cell is written only between two zero data bits. A one-bit history carries the last data bit of one frame into the clock decision of the next.

Besides plain bytes, the block can send an address mark: the byte A1 with one clock cell left out on purpose, so that a reader can tell it apart from any normal data. It can also send the last frame again, cell for cell, without encoding it a second time. A separate, independent path takes a received 16-cell raw frame and returns the data byte held in its data cells. Phase locking, data separation, CRC and sector sequencing are handled elsewhere.

Top module: `cell_codec`

## Requirements
- R1: After reset cell_valid is 0, in_ready is 1, dec_valid is 0 and the MFM history bit is 0.
- R2: A request taken at a rising edge in which in_ready is 1 gives cell_valid high for exactly 16 cycles, starting just after that edge. cell_out then carries frame bit 15 first and bit 0 last. Bit 2k+1 is the clock cell and bit 2k the data cell for data bit k.
- R3: With fm_sel = 1 (FM), every clock cell of a byte frame is 1, so 0x00 gives 0xAAAA and 0xFF gives 0xFFFF.
- R4: With fm_sel = 0 (MFM), a clock cell is 1 only when the data bit before it and the data bit after it are both 0.
- R5: In MFM the clock cell in front of data bit 7 uses, as its left neighbour, the history bit. The history bit is the data bit 0 of the last byte or mark sent. After reset, 0x01 gives 0xAAA9, and then 0x00 gives 0x2AAA.
- R6: A mark request sends the frame of byte 0xA1 with the clock cell in front of data bit 2 (frame bit 5) forced to 0. This gives 0x4489 in MFM and 0xEE8B in FM. The history bit becomes 1 afterwards.
- R7: A resend request sends again the last frame produced from a byte or a mark, unchanged, and leaves the history bit as it was.
- R8: When requests compete in a cycle in which in_ready is 1, mark_req wins over resend_req and resend_req wins over in_valid. A losing byte is not consumed and is sent on a later accept.
- R9: in_ready is 1 while the serializer is idle or is showing the last cell of a frame. A request taken in that last-cell cycle starts the next frame with no gap between frames.
- R10: One cycle after raw_valid, dec_valid pulses for one cycle. dec_byte bit k then equals raw_in bit 2k, and the clock cells are ignored, so 0x4489 decodes to 0xA1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fm_sel | input | 1 | 1 selects FM, 0 selects MFM |
| in_data | input | 8 | Byte to encode |
| in_valid | input | 1 | in_data holds a byte to send |
| in_ready | output | 1 | A request may be taken at the next edge |
| mark_req | input | 1 | Send the address mark frame |
| resend_req | input | 1 | Send the last frame again |
| cell_out | output | 1 | Serial cell stream |
| cell_valid | output | 1 | cell_out carries a frame cell |
| raw_in | input | 16 | Received raw frame to decode |
| raw_valid | input | 1 | raw_in is valid |
| dec_byte | output | 8 | Decoded data byte |
| dec_valid | output | 1 | dec_byte updated this cycle |

## Verification
The assertions assume that mark_req, resend_req and in_valid are changed only away from the rising edge. They also assume that fm_sel stays fixed while a frame is being taken, and that a resend is not asked for before any frame has been produced. The stimulus sets and clears every request on the falling edge, waits for in_ready before counting a request as taken, and sets the density before it issues each request. Decoder stimulus consists of single raw_valid pulses, so each pulse can be matched to one dec_valid pulse.

// File: rtl/cell_codec_pkg.sv
package cell_codec_pkg;
   typedef enum logic [1:0] {
      TAKE_NONE  = 2'd0,
      TAKE_BYTE  = 2'd1,
      TAKE_MARK  = 2'd2,
      TAKE_AGAIN = 2'd3
   } take_e;
endpackage

// File: rtl/cell_encoder.sv
module cell_encoder #(
   parameter int BYTE_W    = 8,
   parameter int MARK_GAP  = 2,
   localparam int FRAME_W  = 2 * BYTE_W
) (
   input  logic [BYTE_W-1:0]  data_in,
   input  logic               prev_bit,
   input  logic               fm_mode,
   input  logic               drop_clock,
   output logic [FRAME_W-1:0] frame
);
   // left neighbour of each data bit: the next higher bit, or the history bit
   logic [BYTE_W:0] chain;
   assign chain = {prev_bit, data_in};

   for (genvar k = 0; k < BYTE_W; k++) begin : g_cell
      logic clk_cell;
      if (k == MARK_GAP) begin : g_gap
         assign clk_cell = !drop_clock && (fm_mode || (!chain[k+1] && !data_in[k]));
      end else begin : g_norm
         assign clk_cell = fm_mode || (!chain[k+1] && !data_in[k]);
      end
      assign frame[2*k+1] = clk_cell;
      assign frame[2*k]   = data_in[k];
   end
endmodule

// File: rtl/cell_serializer.sv
module cell_serializer #(
   parameter int FRAME_W = 16,
   localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_frame,
   output logic               load_ok,
   output logic               cell_out,
   output logic               cell_valid
);
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '0;
         remain <= '0;
      end else if (load) begin
         shreg  <= load_frame;
         remain <= CNT_W'(FRAME_W);
      end else if (remain != '0) begin
         shreg  <= {shreg[FRAME_W-2:0], 1'b0};
         remain <= remain - 1'b1;
      end
   end

   assign load_ok    = (remain <= CNT_W'(1));
   assign cell_valid = (remain != '0);
   assign cell_out   = shreg[FRAME_W-1];

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= CNT_W'(FRAME_W)); // R2
   AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (remain == CNT_W'(FRAME_W)) && cell_valid); // R2
   AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && remain != '0) |=> (remain == $past(remain) - 1'b1)); // R2
   AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> load_ok); // R9
endmodule

// File: rtl/cell_decoder.sv
module cell_decoder #(
   parameter int BYTE_W   = 8,
   localparam int FRAME_W = 2 * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] raw,
   input  logic               raw_valid,
   output logic [BYTE_W-1:0]  byte_out,
   output logic               byte_valid
);
   logic [BYTE_W-1:0] picked;
   for (genvar k = 0; k < BYTE_W; k++) begin : g_pick
      assign picked[k] = raw[2*k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_out   <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= raw_valid;
         if (raw_valid) byte_out <= picked;
      end
   end

   AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      raw_valid |=> byte_valid); // R10
   AST_DEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_valid |=> !byte_valid && $stable(byte_out)); // R10
endmodule

// File: rtl/cell_codec.sv
module cell_codec #(
   parameter int          BYTE_W    = 8,
   parameter logic [7:0]  MARK_BYTE = 8'hA1,
   parameter int          MARK_GAP  = 2,
   localparam int         FRAME_W   = 2 * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fm_sel,
   input  logic [BYTE_W-1:0]  in_data,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               mark_req,
   input  logic               resend_req,
   output logic               cell_out,
   output logic               cell_valid,
   input  logic [FRAME_W-1:0] raw_in,
   input  logic               raw_valid,
   output logic [BYTE_W-1:0]  dec_byte,
   output logic               dec_valid
);
   import cell_codec_pkg::*;

   if (BYTE_W < 2)                   $error("BYTE_W must be at least 2");
   if (MARK_GAP >= BYTE_W)           $error("MARK_GAP must name a data bit");
   if (BYTE_W > 8 || BYTE_W < 8)     $error("mark byte is defined for 8-bit bytes");

   take_e              take;
   logic               load_ok;
   logic               hist;
   logic [FRAME_W-1:0] saved;
   logic [FRAME_W-1:0] enc_frame;
   logic [FRAME_W-1:0] load_frame;
   logic [BYTE_W-1:0]  enc_src;

   always_comb begin
      take = TAKE_NONE;
      if (load_ok) begin
         if (mark_req)        take = TAKE_MARK;
         else if (resend_req) take = TAKE_AGAIN;
         else if (in_valid)   take = TAKE_BYTE;
      end
   end

   assign in_ready = load_ok;
   assign enc_src  = (take == TAKE_MARK) ? MARK_BYTE[BYTE_W-1:0] : in_data;

   cell_encoder #(.BYTE_W(BYTE_W), .MARK_GAP(MARK_GAP)) u_enc (
      .data_in    (enc_src),
      .prev_bit   (hist),
      .fm_mode    (fm_sel),
      .drop_clock (take == TAKE_MARK),
      .frame      (enc_frame)
   );

   assign load_frame = (take == TAKE_AGAIN) ? saved : enc_frame;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist  <= 1'b0;
         saved <= '0;
      end else if (take == TAKE_BYTE || take == TAKE_MARK) begin
         hist  <= enc_src[0];
         saved <= enc_frame;
      end
   end

   cell_serializer #(.FRAME_W(FRAME_W)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (take != TAKE_NONE),
      .load_frame (load_frame),
      .load_ok    (load_ok),
      .cell_out   (cell_out),
      .cell_valid (cell_valid)
   );

   cell_decoder #(.BYTE_W(BYTE_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw        (raw_in),
      .raw_valid  (raw_valid),
      .byte_out   (dec_byte),
      .byte_valid (dec_valid)
   );

   AST_MARK_HIST: assert property (@(posedge clk) disable iff (!rst_n)
      (take == TAKE_MARK) |=> (hist == MARK_BYTE[0])); // R6
   AST_RESEND_HIST: assert property (@(posedge clk) disable iff (!rst_n)
      (take == TAKE_AGAIN) |=> $stable(hist) && $stable(saved)); // R7
   AST_BYTE_HIST: assert property (@(posedge clk) disable iff (!rst_n)
      (take == TAKE_BYTE) |=> (hist == $past(in_data[0]))); // R5
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_valid && !in_ready) |=> cell_valid); // R9
endmodule

// File: tb/tb_cell_codec.sv
module tb_cell_codec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fm_sel = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        mark_req = 1'b0;
   logic        resend_req = 1'b0;
   logic        cell_out, cell_valid;
   logic [15:0] raw_in = '0;
   logic        raw_valid = 1'b0;
   logic [7:0]  dec_byte;
   logic        dec_valid;

   int checks = 0;
   int errors = 0;
   logic model_hist = 1'b0;
   logic [15:0] model_last = '0;

   always #5 clk = ~clk;

   cell_codec dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] enc(input logic [7:0] b, input logic prev, input logic fm);
      logic [15:0] f;
      logic p;
      p = prev;
      for (int k = 7; k >= 0; k--) begin
         f[2*k+1] = fm | (~p & ~b[k]);
         f[2*k]   = b[k];
         p = b[k];
      end
      return f;
   endfunction

   // samples 16 cells starting at the current falling edge
   task automatic grab(output logic [15:0] f, output logic all_valid);
      all_valid = 1'b1;
      for (int i = 0; i < 16; i++) begin
         if (i > 0) @(negedge clk);
         f[15-i] = cell_out;
         all_valid &= cell_valid;
      end
   endtask

   // kind: 0 byte, 1 mark, 2 resend
   task automatic send(input int kind, input logic [7:0] b, input string req, input logic [15:0] exp);
      logic [15:0] f;
      logic v;
      @(negedge clk);
      in_data = b;
      in_valid = (kind == 0);
      mark_req = (kind == 1);
      resend_req = (kind == 2);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; mark_req = 1'b0; resend_req = 1'b0;
      grab(f, v);
      check(req, f, exp);
      check("R2 valid span", v, 1'b1);
      @(negedge clk);
      check("R2 valid ends after 16 cells", cell_valid, 1'b0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 cell_valid", cell_valid, 1'b0);
      check("R1 in_ready", in_ready, 1'b1);
      check("R1 dec_valid", dec_valid, 1'b0);
   endtask

   task automatic t_fm;
      fm_sel = 1'b1;
      send(0, 8'h00, "R3 FM 0x00", 16'hAAAA);
      send(0, 8'hFF, "R3 FM 0xFF", 16'hFFFF);
      send(0, 8'h5C, "R3 FM 0x5C", enc(8'h5C, 1'b0, 1'b1));
      model_hist = 1'b0; model_last = enc(8'h5C, 1'b0, 1'b1);
   endtask

   task automatic t_mfm;
      fm_sel = 1'b0;
      send(0, 8'h01, "R5 MFM 0x01 after reset history", 16'hAAA9);
      send(0, 8'h00, "R5 MFM 0x00 after bit0=1", 16'h2AAA);
      send(0, 8'h36, "R4 MFM 0x36", enc(8'h36, 1'b0, 1'b0));
      send(0, 8'h80, "R4 MFM 0x80", enc(8'h80, 1'b0, 1'b0));
      model_hist = 1'b0; model_last = enc(8'h80, 1'b0, 1'b0);
   endtask

   task automatic t_mark;
      fm_sel = 1'b0;
      send(1, 8'h00, "R6 MFM mark", 16'h4489);
      send(0, 8'h00, "R6 history 1 after mark", 16'h2AAA);
      fm_sel = 1'b1;
      send(1, 8'h00, "R6 FM mark", 16'hEE8B);
      model_hist = 1'b1; model_last = 16'hEE8B;
   endtask

   task automatic t_resend;
      send(2, 8'h00, "R7 resend of mark", 16'hEE8B);
      fm_sel = 1'b0;
      send(0, 8'h3C, "R7 byte", enc(8'h3C, 1'b1, 1'b0));
      send(2, 8'hFF, "R7 resend of byte", enc(8'h3C, 1'b1, 1'b0));
      // history still 0 from 0x3C, not changed by resend
      send(0, 8'h00, "R7 history kept over resend", 16'hAAAA);
   endtask

   task automatic t_priority;
      logic [15:0] f;
      logic v;
      fm_sel = 1'b0;
      @(negedge clk);
      in_data = 8'h55; in_valid = 1'b1; mark_req = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      mark_req = 1'b0;
      grab(f, v);
      check("R8 mark wins over byte", f, 16'h4489);
      @(negedge clk);
      in_valid = 1'b0;
      grab(f, v);
      check("R8 held byte sent after mark", f, enc(8'h55, 1'b1, 1'b0));
      check("R9 no gap after mark", v, 1'b1);
      // resend beats byte
      @(negedge clk);
      @(negedge clk);
      in_data = 8'h00; in_valid = 1'b1; resend_req = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      resend_req = 1'b0;
      grab(f, v);
      check("R8 resend wins over byte", f, enc(8'h55, 1'b1, 1'b0));
      @(negedge clk);
      in_valid = 1'b0;
      grab(f, v);
      check("R8 byte after resend", f, 16'h2AAA);
   endtask

   task automatic t_b2b;
      logic [31:0] s;
      logic v;
      fm_sel = 1'b1;
      @(negedge clk);
      @(negedge clk);
      in_data = 8'hC3; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_data = 8'h18;
      v = 1'b1;
      for (int i = 0; i < 32; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 15) check("R9 ready on last cell", in_ready, 1'b1);
         if (i == 16) in_valid = 1'b0;
         s[31-i] = cell_out;
         v &= cell_valid;
      end
      check("R9 back-to-back frames", s, {enc(8'hC3, 1'b0, 1'b1), enc(8'h18, 1'b1, 1'b1)});
      check("R9 no gap", v, 1'b1);
      @(negedge clk);
      check("R2 idle after stream", cell_valid, 1'b0);
   endtask

   task automatic decode(input logic [15:0] r, input logic [7:0] exp, input string req);
      @(negedge clk);
      raw_in = r; raw_valid = 1'b1;
      @(negedge clk);
      raw_valid = 1'b0;
      check(req, {dec_valid, dec_byte}, {1'b1, exp});
      @(negedge clk);
      check("R10 dec_valid one pulse", dec_valid, 1'b0);
   endtask

   task automatic t_decode;
      decode(16'h4489, 8'hA1, "R10 decode mark");
      decode(16'hAAA9, 8'h01, "R10 decode 0x01");
      decode(16'hAAAA, 8'h00, "R10 clocks ignored");
      decode(16'h5555, 8'hFF, "R10 all data cells");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fm();
      // fresh reset so MFM history starts at 0
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mfm();
      t_mark();
      t_resend();
      t_priority();
      t_b2b();
      t_decode();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule